// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Port Decoder

This block serves the controller-wide register ports of a four-channel legacy DMA controller. A port index of four bits and an eight-bit data byte arrive with a write or read strobe. Indices 8 to 15 belong to this block. Indices 0 to 7 belong to the per-channel address and count file, so this block ignores them. The block keeps the command byte, a four-bit channel mask, an eight-bit status byte and a six-bit mode word for each channel. It decodes each mode word into its operation, autoinitialize, decrement and transfer-mode fields and drives them as plain pins.

Status bits 7:4 are the request flags. Bits 3:0 are the terminal-count flags. Software can raise or drop a request through the request port, and the transfer side can raise or drop one through the hold and release inputs. The transfer side reports terminal count on `tc_hit`. When the clear-flip-flop port or the master-reset port is written, the block sends a one-cycle `ff_clear` pulse to the channel register file so that its low/high byte pointer returns to the low byte.

None of this traffic is a data stream, so every pin is a plain control or status pin and nothing can stall. A read always answers exactly one cycle after the strobe, with `rvalid` high. A write always takes effect at the clock edge where it is sampled.

Top module: `dmac_ctl_ports`

## Requirements
- R1: After reset, `chan_mask` is 4'hF, `ctl_cmd` is 0, all mode fields are 0, the status byte is 0, and `ff_clear` and `rvalid` are low.
- R2: A write to index 8 stores `wdata` in `ctl_cmd` only if no bit other than bit 2 (the controller-disable bit) is set. Any other value leaves `ctl_cmd` unchanged.
- R3: A write to index 9 selects channel `wdata[1:0]`. If `wdata[2]` is 1, status bit (channel+4) is set. If `wdata[2]` is 0, status bits (channel+4) and (channel) are both cleared.
- R4: A write to index 10 sets `chan_mask[wdata[1:0]]` when `wdata[2]` is 1 and clears it when `wdata[2]` is 0. The other mask bits keep their values.
- R5: A write to index 11 stores `wdata[7:2]` as the mode of channel `wdata[1:0]`. For channel c, `mode_op[2c+1:2c]` is bits 3:2, `mode_auto[c]` is bit 4, `mode_dec[c]` is bit 5, and `mode_xfer[2c+1:2c]` is bits 7:6.
- R6: A write to index 12 gives `ff_clear` high for exactly the following cycle and changes no other state.
- R7: A write to index 13 pulses `ff_clear` in the following cycle, clears the status byte and `ctl_cmd`, sets `chan_mask` to 4'hF, and keeps the mode words.
- R8: A write to index 14 clears all four mask bits. A write to index 15 loads `chan_mask` from `wdata[3:0]`.
- R9: A read strobe gives `rvalid` high in the next cycle, together with `rdata`. `rdata` is the status byte for index 8, `{4'h0, chan_mask}` for index 15, and 0 for any other index. When `rvalid` is low, `rdata` is 0.
- R10: A status read returns the status held before the read, then clears bits 3:0. A `tc_hit` bit in the same cycle still sets its flag.
- R11: `hold_req[c]` sets status bit (c+4) and `rel_req[c]` clears it. Release wins over hold, and both win over a request-port write or master reset in the same cycle.
- R12: `tc_hit[c]` sets status bit c. It wins over a request-port clear in the same cycle.
- R13: Writes to indices 0 to 7 change no state in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| port_idx | input | 4 | Register port index |
| wdata | input | 8 | Write data |
| hold_req | input | 4 | Per-channel external request set |
| rel_req | input | 4 | Per-channel external request clear |
| tc_hit | input | 4 | Per-channel terminal-count report |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 8 | Read data |
| ctl_cmd | output | 8 | Accepted command byte (bit 2: controller disabled) |
| chan_mask | output | 4 | Channel mask, 1 = masked |
| mode_op | output | 8 | Per-channel operation field, two bits each |
| mode_auto | output | 4 | Per-channel autoinitialize flag |
| mode_dec | output | 4 | Per-channel address-decrement flag |
| mode_xfer | output | 8 | Per-channel transfer mode, two bits each |
| ff_clear | output | 1 | One-cycle byte-pointer clear pulse |

## Verification
The bench concentrates on cycles where several sources update the status byte at once:
- A status read together with a terminal-count report. A design that applied the read-clear last would lose that terminal count.
- A request-port clear together with `tc_hit` or `hold_req`. Wrong precedence here shows up as a stale or missing flag on the next status read.
- A command byte that carries one unsupported bit. A design that masked the byte instead of rejecting it would expose a partial command on `ctl_cmd`.
- Master reset followed by a mode readout. A design that reset the mode words would zero the mode pins.
- Writes below index 8. A design that ignored bit 3 of the index would alias them onto the mask and command ports.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  localparam int NCH   = 4;
  localparam int CH_W  = $clog2(NCH);
  localparam int DW    = 8;
  localparam int IDX_W = 4;
  localparam int OFS_W = IDX_W - 1;
  localparam int MODE_W = DW - CH_W;

  // port offsets within the controller half of the index space (index - 8)
  typedef enum logic [OFS_W-1:0] {
    OFS_CMD   = 3'd0,
    OFS_REQ   = 3'd1,
    OFS_SMASK = 3'd2,
    OFS_MODE  = 3'd3,
    OFS_FFCLR = 3'd4,
    OFS_MRST  = 3'd5,
    OFS_MCLR  = 3'd6,
    OFS_MALL  = 3'd7
  } ctl_ofs_e;

  // only the controller-disable bit may be set in an accepted command
  localparam logic [DW-1:0] CMD_KEEP_BITS = 8'h04;
  localparam int SET_BIT = CH_W;  // data bit choosing set or clear

  typedef struct packed {
    logic [1:0] xfer;
    logic       dec;
    logic       autoi;
    logic [1:0] op;
  } mode_t;
endpackage

// File: rtl/dmac_cmd_reg.sv
`timescale 1ns/1ps
module dmac_cmd_reg
  import dmac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          mrst,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd
);
  logic accept;
  assign accept = ((wdata & ~CMD_KEEP_BITS) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cmd <= '0;
    else if (mrst)           cmd <= '0;
    else if (wr && accept)   cmd <= wdata;
  end
endmodule

// File: rtl/dmac_mask_reg.sv
`timescale 1ns/1ps
module dmac_mask_reg
  import dmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            single_wr,
  input  logic            clr_all,
  input  logic            wr_all,
  input  logic            mrst,
  input  logic [CH_W-1:0] sel,
  input  logic            set_bit,
  input  logic [NCH-1:0]  all_bits,
  output logic [NCH-1:0]  mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask <= '1;
    else if (mrst)      mask <= '1;
    else if (clr_all)   mask <= '0;
    else if (wr_all)    mask <= all_bits;
    else if (single_wr) mask[sel] <= set_bit;
  end
endmodule

// File: rtl/dmac_status_reg.sv
`timescale 1ns/1ps
module dmac_status_reg
  import dmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_wr,
  input  logic [CH_W-1:0] req_ch,
  input  logic            req_set,
  input  logic            mrst,
  input  logic            rd_clr,
  input  logic [NCH-1:0]  tc_hit,
  input  logic [NCH-1:0]  hold_req,
  input  logic [NCH-1:0]  rel_req,
  output logic [2*NCH-1:0] status
);
  logic [NCH-1:0] tc_nxt, rq_nxt;

  // precedence: read-clear, port write, master reset, then external inputs
  always_comb begin
    tc_nxt = status[NCH-1:0];
    rq_nxt = status[2*NCH-1:NCH];
    if (rd_clr) tc_nxt = '0;
    if (req_wr) begin
      if (req_set) begin
        rq_nxt[req_ch] = 1'b1;
      end else begin
        rq_nxt[req_ch] = 1'b0;
        tc_nxt[req_ch] = 1'b0;
      end
    end
    if (mrst) begin
      tc_nxt = '0;
      rq_nxt = '0;
    end
    tc_nxt = tc_nxt | tc_hit;
    rq_nxt = (rq_nxt | hold_req) & ~rel_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= {rq_nxt, tc_nxt};
  end
endmodule

// File: rtl/dmac_mode_bank.sv
`timescale 1ns/1ps
module dmac_mode_bank
  import dmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  output logic [2*NCH-1:0] op,
  output logic [NCH-1:0]  autoi,
  output logic [NCH-1:0]  dec,
  output logic [2*NCH-1:0] xfer
);
  logic [CH_W-1:0] sel;
  mode_t           incoming;
  assign sel      = wdata[CH_W-1:0];
  assign incoming = mode_t'(wdata[DW-1:CH_W]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mode_t mode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mode_q <= '0;
      else if (wr && sel == CH_W'(c))      mode_q <= incoming;
    end
    assign op[2*c +: 2]   = mode_q.op;
    assign autoi[c]       = mode_q.autoi;
    assign dec[c]         = mode_q.dec;
    assign xfer[2*c +: 2] = mode_q.xfer;
  end
endmodule

// File: rtl/dmac_ctl_ports.sv
`timescale 1ns/1ps
module dmac_ctl_ports
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] port_idx,
  input  logic [DW-1:0]    wdata,
  input  logic [NCH-1:0]   hold_req,
  input  logic [NCH-1:0]   rel_req,
  input  logic [NCH-1:0]   tc_hit,
  output logic             rvalid,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    ctl_cmd,
  output logic [NCH-1:0]   chan_mask,
  output logic [2*NCH-1:0] mode_op,
  output logic [NCH-1:0]   mode_auto,
  output logic [NCH-1:0]   mode_dec,
  output logic [2*NCH-1:0] mode_xfer,
  output logic             ff_clear
);
  localparam int NPORT = 1 << OFS_W;

  logic             ctl_space;
  logic [OFS_W-1:0] ofs;
  logic [NPORT-1:0] wr_hit, rd_hit;
  logic [2*NCH-1:0] status_q;
  logic [DW-1:0]    rdata_d;

  assign ctl_space = port_idx[IDX_W-1];
  assign ofs       = port_idx[OFS_W-1:0];

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    assign wr_hit[p] = wr_en && ctl_space && (ofs == OFS_W'(p));
    assign rd_hit[p] = rd_en && ctl_space && (ofs == OFS_W'(p));
  end

  dmac_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_hit[OFS_CMD]), .mrst(wr_hit[OFS_MRST]),
    .wdata(wdata), .cmd(ctl_cmd)
  );

  dmac_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n),
    .single_wr(wr_hit[OFS_SMASK]), .clr_all(wr_hit[OFS_MCLR]),
    .wr_all(wr_hit[OFS_MALL]), .mrst(wr_hit[OFS_MRST]),
    .sel(wdata[CH_W-1:0]), .set_bit(wdata[SET_BIT]),
    .all_bits(wdata[NCH-1:0]), .mask(chan_mask)
  );

  dmac_status_reg u_status (
    .clk(clk), .rst_n(rst_n),
    .req_wr(wr_hit[OFS_REQ]), .req_ch(wdata[CH_W-1:0]),
    .req_set(wdata[SET_BIT]), .mrst(wr_hit[OFS_MRST]),
    .rd_clr(rd_hit[OFS_CMD]), .tc_hit(tc_hit),
    .hold_req(hold_req), .rel_req(rel_req), .status(status_q)
  );

  dmac_mode_bank u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_hit[OFS_MODE]), .wdata(wdata),
    .op(mode_op), .autoi(mode_auto), .dec(mode_dec), .xfer(mode_xfer)
  );

  // read mux: status shares offset 0 with command, mask shares offset 7
  always_comb begin
    rdata_d = '0;
    if (rd_hit[OFS_CMD])       rdata_d = status_q;
    else if (rd_hit[OFS_MALL]) rdata_d = {{(DW-NCH){1'b0}}, chan_mask};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid   <= 1'b0;
      rdata    <= '0;
      ff_clear <= 1'b0;
    end else begin
      rvalid   <= rd_en;
      rdata    <= rdata_d;
      ff_clear <= wr_hit[OFS_FFCLR] || wr_hit[OFS_MRST];
    end
  end
endmodule

// File: rtl/dmac_ctl_ports_chk.sv
`timescale 1ns/1ps
module dmac_ctl_ports_chk
  import dmac_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [IDX_W-1:0] port_idx,
  input logic [DW-1:0]    wdata,
  input logic [NCH-1:0]   hold_req,
  input logic [NCH-1:0]   rel_req,
  input logic [NCH-1:0]   tc_hit,
  input logic             rvalid,
  input logic [DW-1:0]    ctl_cmd,
  input logic [NCH-1:0]   chan_mask,
  input logic             ff_clear,
  input logic [2*NCH-1:0] status_q
);
  assert_cmd_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_idx == 4'h8 && (wdata & ~CMD_KEEP_BITS) != '0) |=> $stable(ctl_cmd));

  assert_req_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_idx == 4'h9 && wdata[2] && rel_req == '0)
      |=> status_q[{1'b1, $past(wdata[1:0])}]);

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_idx == 4'hA && wdata[2]) |=> chan_mask[$past(wdata[1:0])]);

  assert_ffclr_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ff_clear) |-> $past(wr_en && (port_idx == 4'hC || port_idx == 4'hD)));

  assert_mrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_idx == 4'hD) |=> (chan_mask == 4'hF && ctl_cmd == '0 && ff_clear));

  assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  assert_rdclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && port_idx == 4'h8 && tc_hit == '0) |=> status_q[NCH-1:0] == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ext
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_req[c] && !rel_req[c]) |=> status_q[c+NCH]);
    assert_rel_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rel_req[c] |=> !status_q[c+NCH]);
    assert_tc_R12: assert property (@(posedge clk) disable iff (!rst_n)
      tc_hit[c] |=> status_q[c]);
  end

  assert_lowidx_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !port_idx[IDX_W-1]) |=> ($stable(chan_mask) && $stable(ctl_cmd)));
endmodule

bind dmac_ctl_ports dmac_ctl_ports_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .port_idx(port_idx), .wdata(wdata), .hold_req(hold_req),
  .rel_req(rel_req), .tc_hit(tc_hit), .rvalid(rvalid),
  .ctl_cmd(ctl_cmd), .chan_mask(chan_mask), .ff_clear(ff_clear),
  .status_q(status_q)
);

// File: tb/test_dmac_ctl_ports.sv
`timescale 1ns/1ps
module test_dmac_ctl_ports;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] port_idx = '0;
  logic [7:0] wdata = '0;
  logic [3:0] hold_req = '0, rel_req = '0, tc_hit = '0;
  logic       rvalid, ff_clear;
  logic [7:0] rdata, ctl_cmd, mode_op, mode_xfer;
  logic [3:0] chan_mask, mode_auto, mode_dec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_mask, m_status, m_cmd, m_rdata, m_rvalid, m_ff;
  int m_mode[4];

  always #4 clk = ~clk;  // 125 MHz

  dmac_ctl_ports i_dmac_ctl_ports (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .port_idx(port_idx), .wdata(wdata), .hold_req(hold_req),
    .rel_req(rel_req), .tc_hit(tc_hit), .rvalid(rvalid), .rdata(rdata),
    .ctl_cmd(ctl_cmd), .chan_mask(chan_mask), .mode_op(mode_op),
    .mode_auto(mode_auto), .mode_dec(mode_dec), .mode_xfer(mode_xfer),
    .ff_clear(ff_clear)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int idx, d, ch, ns;
    idx = port_idx; d = wdata; ch = d % 4;
    ns = m_status;
    m_rvalid = rd_en;
    m_rdata = 0;
    if (rd_en && idx == 8)  m_rdata = m_status;
    if (rd_en && idx == 15) m_rdata = m_mask;
    if (rd_en && idx == 8)  ns = ns & 'hF0;
    m_ff = (wr_en && (idx == 12 || idx == 13)) ? 1 : 0;
    if (wr_en) begin
      case (idx)
        8:  if ((d & ~4) == 0) m_cmd = d;
        9:  if (d & 4) ns = ns | (1 << (ch + 4));
            else ns = ns & ~((1 << (ch + 4)) | (1 << ch));
        10: if (d & 4) m_mask = m_mask | (1 << ch);
            else m_mask = m_mask & ~(1 << ch);
        11: m_mode[ch] = d >> 2;
        13: begin m_cmd = 0; ns = 0; m_mask = 15; end
        14: m_mask = 0;
        15: m_mask = d & 15;
        default: ;
      endcase
    end
    ns = ns | tc_hit;
    ns = ns | (hold_req << 4);
    ns = ns & ~(rel_req << 4);
    m_status = ns & 255;
  endtask

  task automatic compare();
    int eop, eau, ede, exf;
    eop = 0; eau = 0; ede = 0; exf = 0;
    for (int c = 0; c < 4; c++) begin
      eop |= (m_mode[c] & 3) << (2 * c);
      eau |= ((m_mode[c] >> 2) & 1) << c;
      ede |= ((m_mode[c] >> 3) & 1) << c;
      exf |= ((m_mode[c] >> 4) & 3) << (2 * c);
    end
    chk("R4 R7 R8 R13", "chan_mask", chan_mask, m_mask);
    chk("R2 R7 R13", "ctl_cmd", ctl_cmd, m_cmd);
    chk("R5", "mode_op", mode_op, eop);
    chk("R5", "mode_auto", mode_auto, eau);
    chk("R5", "mode_dec", mode_dec, ede);
    chk("R5", "mode_xfer", mode_xfer, exf);
    chk("R6 R7", "ff_clear", ff_clear, m_ff);
    chk("R9", "rvalid", rvalid, m_rvalid);
    chk("R3 R9 R10 R11 R12", "rdata", rdata, m_rdata);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    #1;
    compare();
    wr_en = 0; rd_en = 0; hold_req = 0; rel_req = 0; tc_hit = 0;
  endtask

  task automatic wr(int idx, int d);
    wr_en = 1; port_idx = 4'(idx); wdata = 8'(d);
    step();
  endtask

  task automatic rd(int idx);
    rd_en = 1; port_idx = 4'(idx);
    step();
  endtask

  initial begin
    m_mask = 15; m_status = 0; m_cmd = 0; m_rdata = 0; m_rvalid = 0; m_ff = 0;
    for (int c = 0; c < 4; c++) m_mode[c] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1", "reset mask", chan_mask, 15);
    chk("R1", "reset cmd", ctl_cmd, 0);
    chk("R1", "reset modes", {mode_op, mode_xfer, mode_auto, mode_dec}, 0);
    chk("R1", "reset ff_clear/rvalid", {ff_clear, rvalid}, 0);
    rd(8); step();
    chk("R1", "reset status read", rdata, 0);
    rd(15); step();

    // R2 command acceptance
    wr(8, 'h04); wr(8, 'h05); wr(8, 'h40); wr(8, 'h00); wr(8, 'h80); wr(8, 'h04);

    // R3 request port, R12 terminal count, R10 read clear
    wr(9, 'h06); rd(8); step();
    tc_hit = 4'b1011; step(); rd(8); step(); rd(8); step();
    tc_hit = 4'b0100; step();
    wr(9, 'h02); rd(8); step();
    tc_hit = 4'b0001; rd_en = 1; port_idx = 8; step(); rd(8); step();
    tc_hit = 4'b0010; wr(9, 'h01); rd(8); step();

    // R11 external request inputs and precedence
    hold_req = 4'b1010; step(); rd(8); step();
    hold_req = 4'b0001; rel_req = 4'b0001; step();
    wr(9, 'h07); rel_req = 4'b1000; wr(9, 'h03); rd(8); step();
    hold_req = 4'b0100; wr(9, 'h02); rd(8); step();

    // R4 single mask, R8 group mask
    wr(10, 'h00); wr(10, 'h02); wr(10, 'h05); rd(15); step();
    wr(14, 'h00); rd(15); step();
    wr(15, 'h5A); rd(15); step();

    // R5 mode words
    wr(11, 'hD5); wr(11, 'h2A); wr(11, 'h00); wr(11, 'hFF); wr(11, 'h9F);

    // R6 flip-flop clear, R7 master reset
    wr(12, 'h00); step();
    wr(8, 'h04); hold_req = 4'b0110; tc_hit = 4'b0001; step();
    wr(13, 'h00); rd(8); step(); rd(15); step();
    hold_req = 4'b0001; wr(13, 0); rd(8); step();

    // R13 low indices ignored; R9 reads of other indices give 0
    wr(0, 'h00); wr(3, 'hFF); wr(7, 'h00); wr(5, 'h04);
    rd(12); rd(3); rd(15); step();

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      wr_en = 1'($urandom);
      rd_en = 1'($urandom);
      port_idx = 4'($urandom);
      wdata = ($urandom % 3 == 0) ? 8'($urandom & 'h07) : 8'($urandom);
      hold_req = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
      rel_req  = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
      tc_hit   = ($urandom % 5 == 0) ? 4'($urandom) : 4'h0;
      step();
    end
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule